// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to sixteen interrupt sources into a pending register, filters them through a mask, and picks the single most urgent source. It then presents an interrupt request and a vector address to the core's sequencer. A source's bit index sets both its priority and its vector. The lowest index is the most urgent, and the vector is a fixed base plus four times the index. The two most urgent slots bypass both the mask and the global enable. Unassigned slots can serve as software interrupts: software writes ones into the pending register to raise them.

The core takes an interrupt by pulsing an acknowledge while the request is high. That clears the selected pending bit and marks the slot as active. A return pulse retires the most urgent active slot. A control register holds a global enable and a nesting enable. With nesting off, nothing new is taken while any slot is active. With nesting on, only a source more urgent than every active slot can preempt.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the mask, pending, control and active registers all read zero, and irq_o is low.
- R2: The register port uses reg_addr_i to select the register: 0 is the mask, 1 is pending, 2 is control (bit 0 is the global enable, bit 1 is the nesting enable) and 3 is active. A mask or control write takes effect on the next cycle. A pending write sets the bits written as 1 and leaves the other bits alone. Writes to the active register have no effect.
- R3: A high request line sets the pending bit of the same index on the next clock.
- R4: The controller selects the lowest index of pending AND (mask OR the non-maskable bits). When irq_o is high, vec_o equals 0x010000 plus four times that index. When irq_o is low, vec_o is zero.
- R5: Sources 0 and 1 raise irq_o even when their mask bits are clear and the global enable is off.
- R6: With the global enable off, maskable sources (index 2 and above) never raise irq_o.
- R7: An ack_i while irq_o is high clears the selected pending bit and sets the matching active bit on the next clock. A request or pending write to that bit in the same cycle keeps the pending bit set.
- R8: With nesting disabled, irq_o stays low while any active bit is set.
- R9: With nesting enabled and a slot active, irq_o rises only for a candidate whose index is below the lowest active index.
- R10: rti_i clears the lowest-index active bit on the next clock. A return pulse has no effect when no slot is active.
- R11: An ack_i while irq_o is low changes neither the pending nor the active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Request lines, one per slot |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Read data of the selected register |
| ack_i | input | 1 | Core takes the presented interrupt |
| rti_i | input | 1 | Core returns from the current interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | ADDR_W | Vector address of the selected source |
| active_o | output | N_SRC | Slots currently in service |

## Verification
The bench builds the block with its defaults: sixteen slots, two non-maskable slots and 24-bit vectors. At that size, every vector from 0x010000 through 0x01003C is reachable. The non-maskable boundary between index 1 and index 2 is exercised under both settings of the global enable. Random request, write, ack and return traffic drives nesting up to several levels. This covers preemption by a more urgent slot, blocking by a less urgent one, and an ack that collides with a fresh request for the same slot.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_PEND = 2'd1,
    REG_CTRL = 2'd2,
    REG_ACT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic nest;
    logic gie;
  } ctrl_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     in_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     first_o
);

  // one-hot of the lowest set bit
  for (genvar g = 0; g < N; g++) begin : g_first
    if (g == 0) begin : g_lsb
      assign first_o[g] = in_i[g];
    end else begin : g_upper
      assign first_o[g] = in_i[g] & ~(|in_i[g-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (first_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign vld_o = |in_i;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] pend_q,
  output ctrl_t            ctrl_q
);

  logic [N_SRC-1:0] sw_set;

  assign sw_set = (we_i && sel_i == REG_PEND) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (we_i && sel_i == REG_MASK) mask_q <= wdata_i;
      if (we_i && sel_i == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i[1:0]);
      // new requests win over an acknowledge clear
      pend_q <= (pend_q & ~clr_i) | req_i | sw_set;
    end
  end

endmodule

// File: rtl/irq_active.sv
module irq_active #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             rti_i,
  output logic [N_SRC-1:0] act_q,
  output logic             lo_vld_o,
  output logic [IDX_W-1:0] lo_idx_o
);

  logic [N_SRC-1:0] lo_first;

  irq_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_lo_enc (
    .in_i    (act_q),
    .vld_o   (lo_vld_o),
    .idx_o   (lo_idx_o),
    .first_o (lo_first)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else begin
      act_q <= (act_q & ~(rti_i ? lo_first : '0)) | set_i;
    end
  end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned        N_SRC    = 16,
  parameter int unsigned        N_NMI    = 2,
  parameter int unsigned        ADDR_W   = 24,
  parameter logic [ADDR_W-1:0]  VEC_BASE = 24'h010000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  input  logic              ack_i,
  input  logic              rti_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [N_SRC-1:0]  active_o
);

  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam logic [N_SRC-1:0] NMI_MASK = {{(N_SRC-N_NMI){1'b0}}, {N_NMI{1'b1}}};

  reg_sel_e         sel;
  logic [N_SRC-1:0] mask_q, pend_q, act_q;
  ctrl_t            ctrl_q;
  logic             gie, nest;
  logic [N_SRC-1:0] eff, c_first, clr;
  logic             c_vld, a_vld, allow, take;
  logic [IDX_W-1:0] c_idx, a_idx;

  assign sel  = reg_sel_e'(reg_addr_i);
  assign gie  = ctrl_q.gie;
  assign nest = ctrl_q.nest;

  irq_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (sel),
    .wdata_i (reg_wdata_i),
    .req_i   (req_i),
    .clr_i   (clr),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .ctrl_q  (ctrl_q)
  );

  // non-maskable slots bypass mask and global enable
  assign eff = pend_q & (mask_q | NMI_MASK) & (gie ? {N_SRC{1'b1}} : NMI_MASK);

  irq_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_cand_enc (
    .in_i    (eff),
    .vld_o   (c_vld),
    .idx_o   (c_idx),
    .first_o (c_first)
  );

  irq_active #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_active (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (clr),
    .rti_i    (rti_i),
    .act_q    (act_q),
    .lo_vld_o (a_vld),
    .lo_idx_o (a_idx)
  );

  assign allow = !a_vld || (nest && (c_idx < a_idx));
  assign irq_o = c_vld && allow;
  assign take  = ack_i && irq_o;
  assign clr   = take ? c_first : '0;
  assign vec_o = irq_o ? (VEC_BASE + (ADDR_W'(c_idx) << 2)) : '0;
  assign active_o = act_q;

  always_comb begin
    unique case (sel)
      REG_MASK: reg_rdata_o = mask_q;
      REG_PEND: reg_rdata_o = pend_q;
      REG_CTRL: reg_rdata_o = N_SRC'(ctrl_q);
      default:  reg_rdata_o = act_q;
    endcase
  end

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int unsigned       N_SRC    = 16,
  parameter int unsigned       N_NMI    = 2,
  parameter int unsigned       ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'h010000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  req_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [N_SRC-1:0]  reg_wdata_i,
  input logic              ack_i,
  input logic              rti_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [N_SRC-1:0]  active_o,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  pend_q,
  input logic              gie,
  input logic              nest
);

  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam logic [ADDR_W-1:0] VEC_TOP = VEC_BASE + ADDR_W'(4 * (N_SRC - 1));

  logic [ADDR_W-1:0] voff;
  logic [IDX_W-1:0]  vidx;
  int unsigned       lo_act;
  logic              pend_wr;

  assign voff    = vec_o - VEC_BASE;
  assign vidx    = voff[IDX_W+1:2];
  assign pend_wr = reg_we_i && (reg_addr_i == 2'd1) && reg_wdata_i[vidx];

  always_comb begin
    lo_act = N_SRC;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (active_o[i]) lo_act = i;
    end
  end

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_q[vidx] && (mask_q[vidx] || vidx < IDX_W'(N_NMI))) // R4
    else $error("irq without eligible source");

  AST_VEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[1:0] == 2'b00) && (vec_o >= VEC_BASE) && (vec_o <= VEC_TOP)) // R4
    else $error("vector out of range");

  AST_GIE_OFF_NMI_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !gie) |-> vidx < IDX_W'(N_NMI)) // R6
    else $error("maskable irq with global enable off");

  AST_NO_NEST_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nest && active_o != '0) |-> !irq_o) // R8
    else $error("irq while active without nesting");

  AST_NEST_HIGHER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && active_o != '0) |-> (nest && int'(vidx) < lo_act)) // R9
    else $error("preemption by lower priority");

  AST_ACK_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !req_i[vidx] && !pend_wr) |=> !pend_q[$past(vidx)]) // R7
    else $error("pending not cleared on ack");

  AST_ACK_SETS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> active_o[$past(vidx)]) // R7
    else $error("active not set on ack");

  AST_IDLE_ACK_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !rti_i) |=> $stable(active_o)) // R11
    else $error("ack without irq changed active");

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .N_SRC(N_SRC), .N_NMI(N_NMI), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (.*);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] BASE = 24'h010000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ack = 1'b0, rti = 1'b0;
  logic        irq;
  logic [23:0] vec;
  logic [15:0] active;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [15:0] m_mask, m_pend, m_act;
  logic        m_gie, m_nest;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack), .rti_i(rti),
    .irq_o(irq), .vec_o(vec), .active_o(active)
  );

  function automatic int lowest(input logic [15:0] v);
    int r = -1;
    for (int i = 15; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int cand();
    logic [15:0] e = m_pend & (m_mask | 16'h0003);
    if (!m_gie) e = e & 16'h0003;
    return lowest(e);
  endfunction

  function automatic logic exp_irq();
    int c = cand();
    int a = lowest(m_act);
    if (c < 0) return 1'b0;
    return (a < 0) || (m_nest && c < a);
  endfunction

  function automatic logic [23:0] exp_vec();
    if (!exp_irq()) return 24'h0;
    return BASE + 24'(cand() * 4);
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return m_mask;
      2'd1: return m_pend;
      2'd2: return {14'h0, m_nest, m_gie};
      default: return m_act;
    endcase
  endfunction

  task automatic cmp(input logic [23:0] act_v, input logic [23:0] exp_v, input string what, input string tag);
    if (act_v !== exp_v) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic step(input logic [15:0] rq, input logic w, input logic [1:0] ad,
                      input logic [15:0] wd, input logic ak, input logic rt, input string tag);
    logic        ei;
    int          c, a;
    logic [15:0] clr, setb;
    @(negedge clk);
    req = rq; we = w; addr = ad; wdata = wd; ack = ak; rti = rt;
    #1;
    vectors++;
    ei = exp_irq();
    cmp({23'h0, irq}, {23'h0, ei}, "irq_o", tag);
    cmp(vec, exp_vec(), "vec_o", tag);
    cmp({8'h0, rdata}, {8'h0, exp_rdata(ad)}, "rdata", tag);
    cmp({8'h0, active}, {8'h0, m_act}, "active_o", tag);
    // next model state
    c = cand();
    a = lowest(m_act);
    clr = (ak && ei) ? (16'h1 << c) : 16'h0;
    setb = (w && ad == 2'd1) ? wd : 16'h0;
    m_pend = (m_pend & ~clr) | rq | setb;
    if (w && ad == 2'd0) m_mask = wd;
    if (w && ad == 2'd2) begin m_gie = wd[0]; m_nest = wd[1]; end
    if (rt && a >= 0) m_act[a] = 1'b0;
    m_act = m_act | clr;
  endtask

  task automatic idle(input logic [1:0] ad, input string tag);
    step(16'h0, 1'b0, ad, 16'h0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    m_mask = '0; m_pend = '0; m_act = '0; m_gie = 0; m_nest = 0;
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state, all registers
    idle(2'd0, "R1 mask");
    idle(2'd1, "R1 pend");
    idle(2'd2, "R1 ctrl");
    idle(2'd3, "R1 act");
    // R2 register writes
    step(16'h0, 1, 2'd0, 16'hFFF0, 0, 0, "R2 mask write");
    idle(2'd0, "R2 mask readback");
    step(16'h0, 1, 2'd1, 16'h0000, 0, 0, "R2 pend write zero");
    step(16'h0, 1, 2'd3, 16'hFFFF, 0, 0, "R2 act write ignored");
    idle(2'd3, "R2 act unchanged");
    // R3 request latch, R6 gie off blocks maskable
    step(16'h0020, 0, 2'd1, 16'h0, 0, 0, "R3 request");
    idle(2'd1, "R3/R6 pending no irq");
    cmp({23'h0, irq}, 24'h0, "irq_o gie off", "R6");
    step(16'h0, 1, 2'd2, 16'h0001, 0, 0, "R6 gie on");
    idle(2'd2, "R4 select slot5");
    cmp(vec, 24'h010014, "vec slot5", "R4");
    // R5 non-maskable slot 1 (mask bit clear) takes priority
    step(16'h0002, 0, 2'd1, 16'h0, 0, 0, "R5 nmi request");
    idle(2'd1, "R5 nmi selected");
    cmp(vec, 24'h010004, "vec slot1", "R5");
    step(16'h0, 0, 2'd1, 16'h0, 1, 0, "R7 ack slot1");
    idle(2'd3, "R7/R8 active blocks");
    cmp({8'h0, active}, 24'h000002, "active slot1", "R7");
    // R9 nesting
    step(16'h0, 1, 2'd2, 16'h0003, 0, 0, "R9 nest on");
    idle(2'd1, "R9 lower blocked");
    step(16'h0001, 0, 2'd1, 16'h0, 0, 0, "R9 slot0 request");
    idle(2'd1, "R9 slot0 preempts");
    cmp(vec, 24'h010000, "vec slot0", "R9");
    step(16'h0, 0, 2'd1, 16'h0, 1, 0, "R7 ack slot0");
    step(16'h0, 0, 2'd3, 16'h0, 1, 0, "R11 ack idle");
    idle(2'd3, "R11 active kept");
    step(16'h0, 0, 2'd3, 16'h0, 0, 1, "R10 rti");
    step(16'h0, 0, 2'd3, 16'h0, 0, 1, "R10 rti");
    idle(2'd1, "R10 slot5 again");
    step(16'h0020, 0, 2'd1, 16'h0, 1, 0, "R7 ack with request");
    idle(2'd1, "R7 pend kept");
    step(16'h0, 0, 2'd3, 16'h0, 0, 1, "R10 rti");
    step(16'h0, 0, 2'd3, 16'h0, 0, 1, "R10 rti none active");
    // slot 15 boundary
    step(16'h0, 1, 2'd0, 16'h8000, 0, 0, "R4 mask slot15");
    step(16'h0, 1, 2'd1, 16'h8000, 0, 0, "R2 sw set slot15");
    step(16'h0, 0, 2'd1, 16'h0, 1, 0, "R4 take slot15");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] rq;
      logic        w;
      logic [1:0]  ad;
      logic [15:0] wd;
      rq = ($urandom % 5 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      w  = ($urandom % 8 == 0);
      ad = 2'($urandom % 4);
      wd = 16'($urandom);
      if (ad == 2'd1) wd = wd & (16'h1 << ($urandom % 16));
      step(rq, w, ad, wd, ($urandom % 3 == 0), ($urandom % 5 == 0), "rand R4 R7 R9 R10");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule